// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps the per-function table of message-signalled interrupt vectors and the array of pending bits beside it. It decides, for every interrupt request that the device logic raises, whether a message goes out at once, is held as pending, or is dropped. Software reaches the table and the pending array through a 32-bit word-access port. Two control levels come from the capability register: the global enable and the function-wide mask.

A request for a masked vector is not lost. Its pending bit is set, and the message is sent by itself once the vector becomes unmasked. That happens when software clears the vector's own mask bit, or when the function-wide mask drops while the feature is enabled. A drop of the function-wide mask starts a sweep that visits every vector from index 0 upward, one per cycle. Each vector also has a use counter kept by the device logic. A vector whose counter is zero ignores requests.

Messages leave through a valid/ready stage holding a 64-bit address and 32-bit data. When that stage is stalled, the operation that would emit is stalled with it, so no message is ever dropped.

Top module: `msgint_vec_ctrl`

## Requirements
- R1: A vector is masked when `cap_enable` is low, when `cap_maskall` is high, or when bit 0 of its control word is set.
- R2: A request on the notify port is ignored when `ntf_vec` is at or above `N_VEC` or when the vector's use count is zero. If the vector is masked, its pending bit is set and no message goes out. Otherwise one message goes out whose address is {word 1, word 0} of the entry and whose data is word 2.
- R3: On the register port with `reg_win`=0, word address 4*v+k selects word k of entry v: 0 is the low address, 1 the high address, 2 the data, and 3 the control word (only bit 0 is stored; the other bits read zero). With `reg_win`=1, word k returns the pending bits of vectors 32k to 32k+31, vector 32k+j in bit j. Writes to that window change nothing.
- R4: A table write that clears the mask bit of a vector that was masked only by that bit, while its pending bit is set, clears the pending bit and sends that vector's message. The message is visible on the cycle after the write is accepted.
- R5: When the effective function mask changes while `cap_enable` is high, `reg_busy` rises and a sweep visits vectors 0 to N_VEC-1, one per cycle. Each vector that is now unmasked, pending and in use has its pending bit cleared and its message sent, in ascending vector order.
- R6: After reset, every pending bit is clear, every address and data word reads zero, every control word reads 1, and no message is valid.
- R7: `use_inc` and `use_dec` raise and lower the use count of `use_vec`. A decrement that brings the count to zero clears the vector's pending bit. An operation whose `use_vec` is at or above `N_VEC` raises `use_err` in the same cycle and changes nothing.
- R8: While `msg_valid` is high and `msg_ready` is low, the message holds steady. `ntf_ready` stays low, and so does a table write that would emit, until the stage drains.
- R9: Read data appears on `reg_rdata`, with `reg_rvalid` high, in the cycle after the read is accepted. A request is accepted on a clock edge where `reg_req` is high and `reg_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_enable | input | 1 | Global enable from the capability register |
| cap_maskall | input | 1 | Function-wide mask from the capability register |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_win | input | 1 | 0 = vector table window, 1 = pending-bit window |
| reg_addr | input | ADDR_W | 32-bit word address within the window |
| reg_wdata | input | 32 | Write data |
| reg_busy | output | 1 | Access held off this cycle |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| ntf_req | input | 1 | Interrupt request from device logic |
| ntf_vec | input | VEC_W | Requested vector |
| ntf_ready | output | 1 | Request accepted this cycle |
| use_inc | input | 1 | Increment the use count |
| use_dec | input | 1 | Decrement the use count |
| use_vec | input | VEC_W | Vector for the use operation |
| use_err | output | 1 | Use operation rejected (vector out of range) |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message taken |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
A pending bit left set on an unmasked vector shows at the ports as a missing message. It also shows in the pending-bit window at the next read, so every request pattern ends with a read of that window. A sweep that skips or reorders vectors shows as the wrong message order within N_VEC+2 cycles of the mask change. A stale use count shows as a request that is dropped or sent against the expected outcome. A message stage that overwrites while stalled shows as a changed `msg_addr` while `msg_ready` is low, and the bench watches for that over several cycles of back-pressure.

// File: rtl/msgint_pkg.sv
// Shared types for the vector table controller.
// Assumes entries are four 32-bit words; only the mask bit of the control word is kept.
package msgint_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        mask;
    } vec_entry_t;

    localparam logic [1:0] W_ADDR_LO = 2'd0;
    localparam logic [1:0] W_ADDR_HI = 2'd1;
    localparam logic [1:0] W_DATA    = 2'd2;
    localparam logic [1:0] W_CTRL    = 2'd3;

endpackage

// File: rtl/msgint_entry_store.sv
// Register storage for the vector entries.
// One write port that writes a single word per cycle; all entries are readable in parallel.
// Assumes the caller has range-checked wr_vec. Reset leaves each entry zeroed with its mask set.
module msgint_entry_store
    import msgint_pkg::*;
#(
    parameter int N_VEC = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_vec,
    input  logic [1:0]       wr_word,
    input  logic [31:0]      wr_data,
    output vec_entry_t       ent [N_VEC]
);

    vec_entry_t ent_q [N_VEC];

    for (genvar v = 0; v < N_VEC; v++) begin : g_ent
        // Per-entry word update, masked after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[v] <= '{addr_lo: '0, addr_hi: '0, data: '0, mask: 1'b1};
            end else if (wr_en && wr_vec == IDX_W'(v)) begin
                case (wr_word)
                    W_ADDR_LO: ent_q[v].addr_lo <= wr_data;
                    W_ADDR_HI: ent_q[v].addr_hi <= wr_data;
                    W_DATA:    ent_q[v].data    <= wr_data;
                    default:   ent_q[v].mask    <= wr_data[0];
                endcase
            end
        end

        assign ent[v] = ent_q[v];

        AST_RST_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !$past(rst_n) |-> (ent_q[v].mask && ent_q[v].data == '0 && ent_q[v].addr_lo == '0)); // R6
    end

endmodule

// File: rtl/msgint_use_count.sv
// Per-vector use counters kept by device logic.
// An increment and a decrement in the same cycle cancel. Counters saturate at the top and stop at zero.
// drop flags the cycle in which a counter falls from one to zero.
module msgint_use_count #(
    parameter int N_VEC = 8,
    parameter int VEC_W = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic [VEC_W-1:0] vec,
    output logic             err,
    output logic [N_VEC-1:0] in_use,
    output logic [N_VEC-1:0] drop
);

    localparam logic [VEC_W-1:0] NV = VEC_W'(N_VEC);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Reject operations on vectors outside the table.
    assign err = (inc || dec) && (vec >= NV);

    for (genvar v = 0; v < N_VEC; v++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic             sel;

        assign sel       = (vec == VEC_W'(v)) && (inc != dec);
        assign in_use[v] = (cnt_q != '0);
        assign drop[v]   = sel && dec && (cnt_q == CNT_ONE);

        // Counter update with saturation at both ends.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (sel && inc && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_ONE;
            end else if (sel && dec && cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_ONE;
            end
        end

        AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (sel && inc && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R7
    end

endmodule

// File: rtl/msgint_out_stage.sv
// One-deep output register for outgoing messages with a valid/ready handshake.
// Assumes the caller loads only when free is high; a loaded message holds until taken.
module msgint_out_stage (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [63:0] ld_addr,
    input  logic [31:0] ld_data,
    output logic        free,
    output logic        msg_valid,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data,
    input  logic        msg_ready
);

    assign free = !msg_valid || msg_ready;

    // Hold, replace or drain the outgoing message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_addr  <= ld_addr;
            msg_data  <= ld_data;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R8
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n) load |-> free); // R8

endmodule

// File: rtl/msgint_vec_ctrl.sv
// Vector table controller for message-signalled interrupts.
// Holds the entries, the pending bits and the use counters, and decides whether to send, latch or drop each request.
// It replays pending vectors when a table write or a function-mask change unmasks them.
// Assumes 1 <= N_VEC <= 2048. One message at most is issued per cycle.
// The sweep, register accesses and notify requests are mutually exclusive.
module msgint_vec_ctrl
    import msgint_pkg::*;
#(
    parameter int N_VEC = 8,
    parameter int CNT_W = 4,
    localparam int IDX_W = (N_VEC > 1) ? $clog2(N_VEC) : 1,
    localparam int VEC_W = IDX_W + 1,
    localparam int ADDR_W = $clog2(N_VEC * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_enable,
    input  logic              cap_maskall,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic              reg_win,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_busy,
    output logic              reg_rvalid,
    output logic [31:0]       reg_rdata,
    input  logic              ntf_req,
    input  logic [VEC_W-1:0]  ntf_vec,
    output logic              ntf_ready,
    input  logic              use_inc,
    input  logic              use_dec,
    input  logic [VEC_W-1:0]  use_vec,
    output logic              use_err,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data
);

    localparam int PBA_BITS  = ((N_VEC + 63) / 64) * 64;
    localparam int PBA_WORDS = PBA_BITS / 32;
    localparam int PW        = (PBA_WORDS > 1) ? $clog2(PBA_WORDS) : 1;
    localparam logic [ADDR_W:0] NV_A  = (ADDR_W + 1)'(N_VEC);
    localparam logic [ADDR_W:0] PBW_A = (ADDR_W + 1)'(PBA_WORDS);
    localparam logic [VEC_W-1:0] NV_V = VEC_W'(N_VEC);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_VEC - 1);

    ctl_state_e          state_q;
    logic                fmask_q;
    logic                fmask_now;
    logic [IDX_W-1:0]    sweep_idx_q;
    logic [N_VEC-1:0]    pend_q, pend_d;
    logic [PBA_BITS-1:0] pba_flat;
    logic [N_VEC-1:0]    mask_vec;
    vec_entry_t          ent [N_VEC];
    logic [N_VEC-1:0]    in_use, drop;
    logic                out_free, out_load;
    logic [IDX_W-1:0]    emit_idx;

    // Function-level mask as the capability bits define it now.
    assign fmask_now = !cap_enable || cap_maskall;

    for (genvar v = 0; v < N_VEC; v++) begin : g_mask
        assign mask_vec[v] = ent[v].mask;
    end

    // ---------------- register port decode ----------------
    logic [ADDR_W-1:0] r_vec_full;
    logic [IDX_W-1:0]  r_vec;
    logic [1:0]        r_word;
    logic              r_vec_ok;
    logic              reg_acc, tbl_wr, tbl_unmask_pend, tbl_replay_clr, sweep_go;

    assign r_vec_full = reg_addr >> 2;
    assign r_vec      = r_vec_full[IDX_W-1:0];
    assign r_word     = reg_addr[1:0];
    assign r_vec_ok   = ({1'b0, r_vec_full} < NV_A);

    // A pending request that this write would unmask, before acceptance.
    assign tbl_unmask_pend = reg_req && reg_we && !reg_win && r_vec_ok && r_word == W_CTRL
                             && !reg_wdata[0] && !fmask_q && ent[r_vec].mask && pend_q[r_vec];
    assign sweep_go  = (state_q == ST_IDLE) && (fmask_now != fmask_q) && cap_enable;
    assign reg_busy  = (state_q != ST_IDLE) || sweep_go || (tbl_unmask_pend && in_use[r_vec] && !out_free);
    assign reg_acc   = reg_req && !reg_busy;
    assign tbl_wr    = reg_acc && reg_we && !reg_win && r_vec_ok;
    assign tbl_replay_clr = reg_acc && tbl_unmask_pend;

    // ---------------- notify path ----------------
    logic [IDX_W-1:0] ntf_idx;
    logic             ntf_acc, ntf_ok, ntf_masked, ntf_emit, ntf_pend;

    assign ntf_idx    = ntf_vec[IDX_W-1:0];
    assign ntf_ready  = (state_q == ST_IDLE) && !sweep_go && !reg_req && out_free;
    assign ntf_acc    = ntf_req && ntf_ready;
    assign ntf_ok     = (ntf_vec < NV_V) && in_use[ntf_idx];
    assign ntf_masked = fmask_q || ent[ntf_idx].mask;
    assign ntf_emit   = ntf_acc && ntf_ok && !ntf_masked;
    assign ntf_pend   = ntf_acc && ntf_ok && ntf_masked;

    // ---------------- sweep path ----------------
    logic sw_hit, sw_emit, sw_stall;

    assign sw_hit   = (state_q == ST_SWEEP) && !fmask_q && !ent[sweep_idx_q].mask && pend_q[sweep_idx_q];
    assign sw_emit  = sw_hit && in_use[sweep_idx_q];
    assign sw_stall = sw_emit && !out_free;

    // Sweep sequencer: one vector per cycle, waits while the output stage is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            fmask_q     <= 1'b1;
            sweep_idx_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (fmask_now != fmask_q) begin
                        fmask_q <= fmask_now;
                        if (cap_enable) begin
                            state_q     <= ST_SWEEP;
                            sweep_idx_q <= '0;
                        end
                    end
                end
                default: begin
                    if (!sw_stall) begin
                        if (sweep_idx_q == LAST) state_q <= ST_IDLE;
                        else sweep_idx_q <= sweep_idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Pending bits: set by masked requests, cleared by replay or by the last release of a vector.
    always_comb begin
        pend_d = pend_q;
        if (ntf_pend) pend_d[ntf_idx] = 1'b1;
        if (sw_hit && !sw_stall) pend_d[sweep_idx_q] = 1'b0;
        if (tbl_replay_clr) pend_d[r_vec] = 1'b0;
        pend_d = pend_d & ~drop;
    end

    // Pending-bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // Source selection for the single message slot.
    always_comb begin
        if (sw_emit)             emit_idx = sweep_idx_q;
        else if (tbl_replay_clr) emit_idx = r_vec;
        else                     emit_idx = ntf_idx;
    end

    assign out_load = (sw_emit && out_free) || (tbl_replay_clr && in_use[r_vec]) || ntf_emit;

    // ---------------- read data ----------------
    logic [31:0]   tbl_word, pba_word;
    logic [PW-1:0] pa;

    assign pba_flat = PBA_BITS'(pend_q);
    assign pa       = reg_addr[PW-1:0];

    // Word select within the vector table window.
    always_comb begin
        tbl_word = '0;
        if (r_vec_ok) begin
            case (r_word)
                W_ADDR_LO: tbl_word = ent[r_vec].addr_lo;
                W_ADDR_HI: tbl_word = ent[r_vec].addr_hi;
                W_DATA:    tbl_word = ent[r_vec].data;
                default:   tbl_word = {31'b0, ent[r_vec].mask};
            endcase
        end
    end

    // Word select within the pending-bit window.
    always_comb begin
        pba_word = '0;
        if ({1'b0, reg_addr} < PBW_A) pba_word = pba_flat[{pa, 5'b0} +: 32];
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_acc && !reg_we;
            if (reg_acc && !reg_we) reg_rdata <= reg_win ? pba_word : tbl_word;
        end
    end

    // ---------------- sub-blocks ----------------
    msgint_entry_store #(.N_VEC(N_VEC), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_vec  (r_vec),
        .wr_word (r_word),
        .wr_data (reg_wdata),
        .ent     (ent)
    );

    msgint_use_count #(.N_VEC(N_VEC), .VEC_W(VEC_W), .CNT_W(CNT_W)) u_use (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (use_inc),
        .dec    (use_dec),
        .vec    (use_vec),
        .err    (use_err),
        .in_use (in_use),
        .drop   (drop)
    );

    msgint_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (out_load),
        .ld_addr   ({ent[emit_idx].addr_hi, ent[emit_idx].addr_lo}),
        .ld_data   (ent[emit_idx].data),
        .free      (out_free),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .msg_ready (msg_ready)
    );

    // ---------------- assertions ----------------
    AST_PEND_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n) (pend_q & ~in_use) == '0); // R7
    AST_IDLE_NO_STALE_PEND: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE && !fmask_q) |-> ((pend_q & ~mask_vec) == '0)); // R4
    AST_SWEEP_EMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (sw_emit && out_free) |=> (msg_valid && !pend_q[$past(sweep_idx_q)])); // R5
    AST_MASKED_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n) ntf_pend |=> pend_q[$past(ntf_idx)] || $past(drop[ntf_idx])); // R2

endmodule

// File: tb/sim_msgint_vec_ctrl.sv
// Self-checking bench: a table of request patterns, then directed tests.
module sim_msgint_vec_ctrl;

    localparam int N = 8;
    localparam int AW = 5;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_enable = 1'b0, cap_maskall = 1'b0;
    logic          reg_req = 1'b0, reg_we = 1'b0, reg_win = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_busy, reg_rvalid;
    logic [31:0]   reg_rdata;
    logic          ntf_req = 1'b0;
    logic [VW-1:0] ntf_vec = '0;
    logic          ntf_ready;
    logic          use_inc = 1'b0, use_dec = 1'b0;
    logic [VW-1:0] use_vec = '0;
    logic          use_err;
    logic          msg_valid, msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic [63:0] log_a [64];
    logic [31:0] log_d [64];
    int          log_n = 0;

    always #5 clk = ~clk;

    msgint_vec_ctrl #(.N_VEC(N), .CNT_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_enable(cap_enable), .cap_maskall(cap_maskall),
        .reg_req(reg_req), .reg_we(reg_we), .reg_win(reg_win), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_busy(reg_busy), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .ntf_req(ntf_req), .ntf_vec(ntf_vec), .ntf_ready(ntf_ready),
        .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec), .use_err(use_err),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Message monitor, sampling between edges.
    always @(negedge clk) begin
        #1;
        if (msg_valid && msg_ready && log_n < 64) begin
            log_a[log_n] = msg_addr;
            log_d[log_n] = msg_data;
            log_n = log_n + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [63:0] exp_addr(input int v);
        return {32'(v), 32'h1000_0000 + 32'(v * 16)};
    endfunction

    function automatic logic [31:0] exp_data(input int v);
        return 32'hD000_0000 + 32'(v);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic win, input int a, input logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_win = win; reg_addr = AW'(a); reg_wdata = d;
        #1;
        while (reg_busy) begin @(negedge clk); #1; end
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic win, input int a, output logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_win = win; reg_addr = AW'(a);
        #1;
        while (reg_busy) begin @(negedge clk); #1; end
        @(negedge clk);
        reg_req = 1'b0;
        check("R9 rvalid", 64'(reg_rvalid), 64'd1);
        d = reg_rdata;
    endtask

    task automatic notify(input int v);
        @(negedge clk);
        ntf_req = 1'b1; ntf_vec = VW'(v);
        #1;
        while (!ntf_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        ntf_req = 1'b0;
    endtask

    task automatic use_op(input logic inc, input int v, output logic err);
        @(negedge clk);
        use_inc = inc; use_dec = !inc; use_vec = VW'(v);
        #1;
        err = use_err;
        @(negedge clk);
        use_inc = 1'b0; use_dec = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    // Request patterns: vector and outcome (0 send, 1 latch pending, 2 ignored).
    typedef struct packed {
        logic [3:0] vec;
        logic [1:0] kind;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{vec: 4'd0, kind: 2'd0},
        '{vec: 4'd3, kind: 2'd1},
        '{vec: 4'd7, kind: 2'd2},
        '{vec: 4'd5, kind: 2'd1},
        '{vec: 4'd2, kind: 2'd0},
        '{vec: 4'd9, kind: 2'd2}
    };

    initial begin
        logic [31:0] rd;
        logic        err;
        int          base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(1);

        // R6: reset state
        check("R6 msg_valid", 64'(msg_valid), 64'd0);
        check("R6 busy", 64'(reg_busy), 64'd0);
        reg_rd(1'b0, 3, rd);  check("R6 ctrl v0", 64'(rd), 64'd1);
        reg_rd(1'b0, 31, rd); check("R6 ctrl v7", 64'(rd), 64'd1);
        reg_rd(1'b0, 10, rd); check("R6 data v2", 64'(rd), 64'd0);
        reg_rd(1'b1, 0, rd);  check("R6 pba", 64'(rd), 64'd0);

        // Program every entry; vectors 3 and 5 keep their own mask.
        for (int v = 0; v < N; v++) begin
            reg_wr(1'b0, v * 4 + 0, exp_addr(v)[31:0]);
            reg_wr(1'b0, v * 4 + 1, exp_addr(v)[63:32]);
            reg_wr(1'b0, v * 4 + 2, exp_data(v));
            reg_wr(1'b0, v * 4 + 3, (v == 3 || v == 5) ? 32'h1 : 32'hFFFF_FFFE);
        end
        reg_rd(1'b0, 10, rd); check("R3 data v2", 64'(rd), 64'(exp_data(2)));
        reg_rd(1'b0, 13, rd); check("R3 addr_hi v3", 64'(rd), 64'd3);
        reg_rd(1'b0, 7, rd);  check("R3 ctrl v1 only bit0", 64'(rd), 64'd0);

        for (int v = 0; v < 7; v++) use_op(1'b1, v, err);
        use_op(1'b1, 8, err); check("R7 use_err range", 64'(err), 64'd1);
        use_op(1'b1, 6, err); check("R7 use_err ok", 64'(err), 64'd0);

        // R1: disabled function masks everything
        notify(0);
        settle(2);
        check("R1 no msg while disabled", 64'(log_n), 64'd0);
        reg_rd(1'b1, 0, rd); check("R1 pba v0", 64'(rd), 64'h1);

        // R5: enabling drops the function mask and replays v0
        @(negedge clk);
        cap_enable = 1'b1;
        #1;
        check("R5 busy on change", 64'(reg_busy), 64'd1);
        settle(N + 4);
        check("R5 replay count", 64'(log_n), 64'd1);
        check("R5 replay addr", log_a[0], exp_addr(0));
        reg_rd(1'b1, 0, rd); check("R5 pba cleared", 64'(rd), 64'd0);

        // R2: table of request patterns
        foreach (ROWS[i]) begin
            base = log_n;
            notify(int'(ROWS[i].vec));
            settle(2);
            if (ROWS[i].kind == 2'd0) begin
                check("R2 sent count", 64'(log_n), 64'(base + 1));
                check("R2 sent addr", log_a[base], exp_addr(int'(ROWS[i].vec)));
                check("R2 sent data", 64'(log_d[base]), 64'(exp_data(int'(ROWS[i].vec))));
            end else begin
                check("R2 nothing sent", 64'(log_n), 64'(base));
            end
        end
        reg_rd(1'b1, 0, rd); check("R2 pba after patterns", 64'(rd), 64'h28);

        // R4: clearing v3 mask replays it
        base = log_n;
        reg_wr(1'b0, 15, 32'h0);
        settle(1);
        check("R4 replay count", 64'(log_n), 64'(base + 1));
        check("R4 replay addr", log_a[base], exp_addr(3));
        reg_rd(1'b1, 0, rd); check("R4 pba", 64'(rd), 64'h20);

        // R5: mask-all, latch v0 and v2, then release in order
        @(negedge clk); cap_maskall = 1'b1;
        settle(N + 4);
        base = log_n;
        notify(0);
        notify(2);
        settle(2);
        check("R1 mask-all blocks", 64'(log_n), 64'(base));
        reg_rd(1'b1, 0, rd); check("R1 pba mask-all", 64'(rd), 64'h25);
        @(negedge clk); cap_maskall = 1'b0;
        settle(N + 4);
        check("R5 sweep count", 64'(log_n), 64'(base + 2));
        check("R5 sweep first", log_a[base], exp_addr(0));
        check("R5 sweep second", log_a[base + 1], exp_addr(2));
        reg_rd(1'b1, 0, rd); check("R5 pba v5 kept", 64'(rd), 64'h20);

        // R8: back-pressure
        base = log_n;
        @(negedge clk); msg_ready = 1'b0;
        notify(1);
        settle(1);
        check("R8 held valid", 64'(msg_valid), 64'd1);
        @(negedge clk);
        ntf_req = 1'b1; ntf_vec = VW'(4);
        #1;
        check("R8 notify stalled", 64'(ntf_ready), 64'd0);
        settle(3);
        check("R8 addr stable", msg_addr, exp_addr(1));
        check("R8 none taken", 64'(log_n), 64'(base));
        @(negedge clk); msg_ready = 1'b1;
        #1;
        while (!ntf_ready) begin @(negedge clk); #1; end
        @(negedge clk); ntf_req = 1'b0;
        settle(2);
        check("R8 both delivered", 64'(log_n), 64'(base + 2));
        check("R8 order first", log_a[base], exp_addr(1));
        check("R8 order second", log_a[base + 1], exp_addr(4));

        // R3: writes to the pending window change nothing
        reg_wr(1'b1, 0, 32'hFFFF_FFFF);
        reg_rd(1'b1, 0, rd); check("R3 pba write ignored", 64'(rd), 64'h20);

        // R7: last release clears pending; the vector then ignores requests
        use_op(1'b0, 5, err);
        reg_rd(1'b1, 0, rd); check("R7 drop clears pending", 64'(rd), 64'd0);
        notify(5);
        settle(1);
        reg_rd(1'b1, 0, rd); check("R7 unused ignored", 64'(rd), 64'd0);

        // R6: reset during operation
        @(negedge clk); cap_enable = 1'b0; rst_n = 1'b0;
        settle(2);
        @(negedge clk); rst_n = 1'b1;
        reg_rd(1'b0, 3, rd);  check("R6 ctrl v0 after reset", 64'(rd), 64'd1);
        reg_rd(1'b0, 0, rd);  check("R6 addr v0 after reset", 64'(rd), 64'd0);
        reg_rd(1'b1, 0, rd);  check("R6 pba after reset", 64'(rd), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule